// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block gathers interrupt events from three kinds of source and turns them into one vectored request for a processor core. The sources are external pins with programmable sensing, internal condition lines such as timer overflow or compare match, and bus event strobes. Each source owns a pending flag and an enable bit. A global enable gates every request. Bus event sources also carry a separate mask bit: their enable decides whether an event is stored, and their mask only holds back the request to the core.

The core takes an interrupt by pulsing an acknowledge together with the vector number it is servicing. This clears the flag of that source and drops the global enable. Software can also clear flags by writing ones into a clear strobe. When several sources request at the same time, the lowest vector number is presented. Vector numbers are assigned in a fixed order: external pins first, then condition lines, then bus events. Vector 0 means no request.

Top module: `irq_ctrl`

## Requirements
- R1: A bus event strobe that arrives while its enable bit is 0 leaves its flag at 0, and the event stays lost after the enable is later set.
- R2: A bus event source requests whenever its flag is 1 and its mask bit is 0, whatever its enable bit is. A flag stored while masked raises the request in the same cycle the mask drops to 0.
- R3: A condition line flag is set at the first clock edge where the line is seen high after being low. This happens even when its enable bit and the global enable are 0. The flag is held until it is cleared. Such a source requests only when its flag, its enable bit and the global enable are all 1.
- R4: An acknowledge with vector number v clears the flag of source v at that clock edge and clears the global enable. A simultaneous global-enable set is ignored.
- R5: A write-one-to-clear strobe takes effect one clock later: the flags named in w1c_bits_i are cleared at the second rising edge after the strobe is presented. If a new event for the same source lands on that edge, the flag stays set.
- R6: Each external pin has a 2-bit sense field at sense_i[2k+1:2k]. With 2'b10 the flag is set on a high-to-low change of the pin, and with 2'b11 on a low-to-high change. A change in the opposite direction does not set the flag.
- R7: With sense 2'b00 the pin requests while its registered value is low, with no flag: the request appears one clock after the pin falls and is gone one clock after the pin rises.
- R8: With sense 2'b01 the pin sets no flag and raises no request, for any pin activity.
- R9: Vector numbering: external pin k is vector k+1, condition line j is vector NUM_PIN+j+1, bus event u is vector NUM_PIN+NUM_COND+u+1. irq_vec_o shows the lowest requesting vector with irq_req_o at 1, or 0 with irq_req_o at 0.
- R10: A condition line that stays high after its flag was cleared does not set the flag again. Only a new low-to-high change does.
- R11: After reset all flags and the global enable are 0. gie_set_i sets the global enable, gie_clr_i clears it (clear wins over set), and while it is 0 no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PIN | External pin levels (synchronous) |
| sense_i | input | 2*NUM_PIN | Sense field per pin |
| cond_i | input | NUM_COND | Internal condition lines |
| usb_ev_i | input | NUM_USB | Bus event strobes, one cycle each |
| en_i | input | NUM_SRC | Per-source enable, indexed by vector-1 |
| usb_mask_i | input | NUM_USB | Per bus event request mask, 1 = held off |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable |
| w1c_i | input | 1 | Write-one-to-clear strobe |
| w1c_bits_i | input | NUM_SRC | Flags to clear, indexed by vector-1 |
| ack_i | input | 1 | Interrupt taken |
| ack_vec_i | input | VEC_W | Vector being taken |
| irq_req_o | output | 1 | Request to the core |
| irq_vec_o | output | VEC_W | Winning vector, 0 when idle |
| flags_o | output | NUM_SRC | Pending flags, indexed by vector-1 |
| gie_o | output | 1 | Global enable state |

## Verification
The priority encoder is swept over every combination of pin and condition enables, crossed with every bus mask pattern, while all eight flags are set. This exercises every pending pattern and compares the vector against the lowest set bit computed in the bench. Directed sequences then set the capture-gating enable and the request-only mask apart from each other. They separate a clear that arrives with a new event from a plain clear, and a condition that persists from one that recurs. Each sense code is driven with both pin directions, so that edge, level and reserved behaviour give different flag and request results.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_t;
endpackage

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] sense_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       pend_o
);
  sense_t sense;
  logic   pin_q, flag_q, fall, rise, set;

  assign sense = sense_t'(sense_i);
  assign fall  = pin_q & ~pin_i;
  assign rise  = ~pin_q & pin_i;
  assign set   = ((sense == SENSE_FALL) & fall) | ((sense == SENSE_RISE) & rise);

  // pin idles high, so reset the sampled copy high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (set)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sense)
      SENSE_LOW:              pend_o = en_i & ~pin_q;
      SENSE_FALL, SENSE_RISE: pend_o = en_i & flag_q;
      default:                pend_o = 1'b0;
    endcase
  end

  assign flag_o = flag_q;

  assert_reserved_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense == SENSE_RSVD) |-> !pend_o);
endmodule

// File: rtl/irq_evt_cell.sv
module irq_evt_cell #(
  parameter bit GATED_CAPTURE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic en_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pend_o
);
  logic flag_q, set;

  generate
    if (GATED_CAPTURE) begin : g_gated
      // strobe source: enable gates capture, mask gates request
      assign set    = ev_i & en_i;
      assign pend_o = flag_q & ~mask_i;

      assert_lost_when_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !flag_q) |=> !flag_q);
      assert_mask_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_i |-> !pend_o);
    end else begin : g_free
      logic cond_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cond_q <= 1'b0;
        else         cond_q <= ev_i;
      end
      // static condition: flag only on the low-to-high change
      assign set    = ev_i & ~cond_q;
      assign pend_o = flag_q & en_i & ~mask_i;

      assert_flag_on_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_i && !cond_q) |=> flag_q);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 8,
  parameter int VEC_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     pend_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = VEC_W'(i + 1);
    end
  end
  assign req_o = |pend_i;

  logic [N-1:0] below;
  assign below = (N'(1) << (vec_o - 1'b1)) - N'(1);

  assert_vec_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> pend_i[vec_o - 1'b1]);
  assert_vec_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((pend_i & below) == '0));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_PIN  = 2,
  parameter int NUM_COND = 2,
  parameter int NUM_USB  = 4,
  localparam int NUM_SRC = NUM_PIN + NUM_COND + NUM_USB,
  localparam int VEC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PIN-1:0]    pin_i,
  input  logic [2*NUM_PIN-1:0]  sense_i,
  input  logic [NUM_COND-1:0]   cond_i,
  input  logic [NUM_USB-1:0]    usb_ev_i,
  input  logic [NUM_SRC-1:0]    en_i,
  input  logic [NUM_USB-1:0]    usb_mask_i,
  input  logic                  gie_set_i,
  input  logic                  gie_clr_i,
  input  logic                  w1c_i,
  input  logic [NUM_SRC-1:0]    w1c_bits_i,
  input  logic                  ack_i,
  input  logic [VEC_W-1:0]      ack_vec_i,
  output logic                  irq_req_o,
  output logic [VEC_W-1:0]      irq_vec_o,
  output logic [NUM_SRC-1:0]    flags_o,
  output logic                  gie_o
);
  localparam int COND_BASE = NUM_PIN;
  localparam int USB_BASE  = NUM_PIN + NUM_COND;

  logic               gie_q;
  logic [NUM_SRC-1:0] w1c_q, clr, pend, flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      w1c_q <= '0;
    end else begin
      w1c_q <= w1c_i ? w1c_bits_i : '0;
      if (ack_i || gie_clr_i) gie_q <= 1'b0;
      else if (gie_set_i)     gie_q <= 1'b1;
    end
  end

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
      localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(s + 1);
      assign clr[s] = (ack_i && (ack_vec_i == MY_VEC)) || w1c_q[s];
    end

    for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
      irq_pin_cell u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i[k]),
        .sense_i (sense_i[2*k +: 2]),
        .en_i    (en_i[k]),
        .clr_i   (clr[k]),
        .flag_o  (flags[k]),
        .pend_o  (pend[k])
      );
    end

    for (genvar j = 0; j < NUM_COND; j++) begin : g_cond
      irq_evt_cell #(.GATED_CAPTURE(1'b0)) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ev_i   (cond_i[j]),
        .en_i   (en_i[COND_BASE + j]),
        .mask_i (1'b0),
        .clr_i  (clr[COND_BASE + j]),
        .flag_o (flags[COND_BASE + j]),
        .pend_o (pend[COND_BASE + j])
      );
    end

    for (genvar u = 0; u < NUM_USB; u++) begin : g_usb
      irq_evt_cell #(.GATED_CAPTURE(1'b1)) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ev_i   (usb_ev_i[u]),
        .en_i   (en_i[USB_BASE + u]),
        .mask_i (usb_mask_i[u]),
        .clr_i  (clr[USB_BASE + u]),
        .flag_o (flags[USB_BASE + u]),
        .pend_o (pend[USB_BASE + u])
      );
    end
  endgenerate

  irq_prio_enc #(.N(NUM_SRC), .VEC_W(VEC_W)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend & {NUM_SRC{gie_q}}),
    .req_o  (irq_req_o),
    .vec_o  (irq_vec_o)
  );

  assign flags_o = flags;
  assign gie_o   = gie_q;

  assert_ack_clears_gie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !gie_o);
  assert_no_req_without_gie_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_o |-> !irq_req_o);
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  localparam int NP = 2, NC = 2, NU = 4, NS = 8, VW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pin_i = '1;
  logic [2*NP-1:0] sense_i = '0;
  logic [NC-1:0] cond_i = '0;
  logic [NU-1:0] usb_ev_i = '0;
  logic [NS-1:0] en_i = '0;
  logic [NU-1:0] usb_mask_i = '0;
  logic          gie_set_i = 1'b0, gie_clr_i = 1'b0, w1c_i = 1'b0, ack_i = 1'b0;
  logic [NS-1:0] w1c_bits_i = '0;
  logic [VW-1:0] ack_vec_i = '0;
  logic          irq_req_o, gie_o;
  logic [VW-1:0] irq_vec_o;
  logic [NS-1:0] flags_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_ctrl #(.NUM_PIN(NP), .NUM_COND(NC), .NUM_USB(NU)) u0 (.*);

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    // R11 reset state
    chk("R11 reset req", 32'(irq_req_o), 0);
    chk("R11 reset vec", 32'(irq_vec_o), 0);
    chk("R11 reset flags", 32'(flags_o), 0);
    chk("R11 reset gie", 32'(gie_o), 0);

    // R3 condition 0 (vector 3, flag bit 2) sets with enables off
    cond_i[0] = 1'b1; step();
    chk("R3 flag set disabled", 32'(flags_o[2]), 1);
    chk("R3 no req disabled", 32'(irq_req_o), 0);
    en_i[2] = 1'b1; #1;
    chk("R3 no req without gie", 32'(irq_req_o), 0);
    gie_set_i = 1'b1; step(); gie_set_i = 1'b0;
    chk("R11 gie set", 32'(gie_o), 1);
    chk("R3 req", 32'(irq_req_o), 1);
    chk("R9 vec cond0", 32'(irq_vec_o), 3);

    // R5 clear delay, R10 persistent condition
    w1c_i = 1'b1; w1c_bits_i = 8'h04; step(); w1c_i = 1'b0;
    chk("R5 not yet cleared", 32'(flags_o[2]), 1);
    step();
    chk("R5 cleared", 32'(flags_o[2]), 0);
    step(); step(); step();
    chk("R10 no re-set while high", 32'(flags_o[2]), 0);
    chk("R10 no req", 32'(irq_req_o), 0);
    cond_i[0] = 1'b0; step(); cond_i[0] = 1'b1; step();
    chk("R10 new rise sets", 32'(flags_o[2]), 1);

    // R4 acknowledge
    ack_i = 1'b1; ack_vec_i = 4'd3; gie_set_i = 1'b1; step();
    ack_i = 1'b0; gie_set_i = 1'b0;
    chk("R4 flag cleared", 32'(flags_o[2]), 0);
    chk("R4 gie cleared", 32'(gie_o), 0);
    chk("R4 no req", 32'(irq_req_o), 0);

    // R5 new event wins over delayed clear
    cond_i[0] = 1'b0; step();
    w1c_i = 1'b1; step(); w1c_i = 1'b0;
    cond_i[0] = 1'b1; step();
    chk("R5 set wins", 32'(flags_o[2]), 1);
    w1c_i = 1'b1; step(); w1c_i = 1'b0; step();
    chk("R5 clear again", 32'(flags_o[2]), 0);
    cond_i[0] = 1'b0; en_i = '0;

    // R1 bus event 0 (vector 5, flag bit 4) lost while disabled
    usb_ev_i[0] = 1'b1; step(); usb_ev_i[0] = 1'b0;
    chk("R1 not captured", 32'(flags_o[4]), 0);
    en_i[4] = 1'b1; step();
    chk("R1 stays lost", 32'(flags_o[4]), 0);

    // R2 mask holds request only
    usb_mask_i[0] = 1'b1; gie_set_i = 1'b1; step(); gie_set_i = 1'b0;
    usb_ev_i[0] = 1'b1; step(); usb_ev_i[0] = 1'b0;
    chk("R2 captured while masked", 32'(flags_o[4]), 1);
    chk("R2 masked no req", 32'(irq_req_o), 0);
    usb_mask_i[0] = 1'b0; #1;
    chk("R2 unmask req", 32'(irq_req_o), 1);
    chk("R2 unmask vec", 32'(irq_vec_o), 5);
    en_i[4] = 1'b0; #1;
    chk("R2 enable not in request", 32'(irq_req_o), 1);
    ack_i = 1'b1; ack_vec_i = 4'd5; step(); ack_i = 1'b0;
    chk("R4 bus flag cleared", 32'(flags_o[4]), 0);

    // R6 rising sense on pin 0
    sense_i = 4'b0011; pin_i[0] = 1'b0; step();
    chk("R6 rise mode ignores fall", 32'(flags_o[0]), 0);
    pin_i[0] = 1'b1; step();
    chk("R6 rise sets", 32'(flags_o[0]), 1);
    ack_i = 1'b1; ack_vec_i = 4'd1; step(); ack_i = 1'b0;
    sense_i = 4'b0010; pin_i[0] = 1'b0; step();
    chk("R6 fall sets", 32'(flags_o[0]), 1);
    ack_i = 1'b1; step(); ack_i = 1'b0;
    pin_i[0] = 1'b1; step();
    chk("R6 fall mode ignores rise", 32'(flags_o[0]), 0);

    // R7 level sense
    sense_i = 4'b0000; en_i[0] = 1'b1; gie_set_i = 1'b1; step(); gie_set_i = 1'b0;
    chk("R7 high no req", 32'(irq_req_o), 0);
    pin_i[0] = 1'b0; #1;
    chk("R7 req waits a clock", 32'(irq_req_o), 0);
    step();
    chk("R7 low req", 32'(irq_req_o), 1);
    chk("R7 low vec", 32'(irq_vec_o), 1);
    chk("R7 no flag", 32'(flags_o[0]), 0);
    pin_i[0] = 1'b1; step();
    chk("R7 release", 32'(irq_req_o), 0);

    // R8 reserved sense
    sense_i = 4'b0001; pin_i[0] = 1'b0; step();
    chk("R8 low no req", 32'(irq_req_o), 0);
    chk("R8 low no flag", 32'(flags_o[0]), 0);
    pin_i[0] = 1'b1; step();
    chk("R8 rise no flag", 32'(flags_o[0]), 0);

    // R11 clear beats set
    gie_set_i = 1'b1; gie_clr_i = 1'b1; step();
    gie_set_i = 1'b0; gie_clr_i = 1'b0;
    chk("R11 clear wins", 32'(gie_o), 0);

    // R9 sweep: all flags set, every enable x mask pattern
    sense_i = 4'b1010; en_i = '1; gie_set_i = 1'b1;
    pin_i = '0; cond_i = '1; usb_ev_i = '1; step();
    gie_set_i = 1'b0; usb_ev_i = '0;
    chk("R9 all flags", 32'(flags_o), 32'hff);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] p;
      int ev;
      en_i[3:0] = c[3:0];
      usb_mask_i = c[7:4];
      p = {~c[7:4], c[3:0]};
      ev = 0;
      for (int b = 7; b >= 0; b--) if (p[b]) ev = b + 1;
      #1;
      chk("R9 sweep req", 32'(irq_req_o), 32'(p != 0));
      chk("R9 sweep vec", 32'(irq_vec_o), 32'(ev));
    end

    finish_run();
  end
endmodule